// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a memory-mapped general-purpose I/O port of up to 32 pins. Software reaches it over a plain word-wide register bus with a word address, a write strobe, write data and a combinational read data word. Each pin has its own output-enable, input-enable and output data bit, which drive the pad control outputs directly.

Pad inputs are brought into the clock domain through a two-flop synchroniser. A per-pin detector then compares each synchronised value with its value one cycle earlier. This catches rising or falling edges, or a level that is held high or low. When a pin's mask bit is set, a detected event latches that pin's pending bit, and it also latches a port-level pending flag in the control word. The single port interrupt output is raised while the port is enabled and any unmasked pin is pending. Software clears pending state by writing ones.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, every register reads zero and pad_oe, pad_ie, pad_out and irq are all zero.
- R2: Writes to word 0 (output enable), word 1 (input enable) and word 2 (data) drive pad_oe, pad_ie and pad_out on the next cycle. A read of word 2 returns, for each pin, the data bit when that pin's output enable is set and the synchronised pad input otherwise.
- R3: Pin p has a 2-bit trigger field at bits 2*(p mod 16)+1 and 2*(p mod 16). Pins 0 to 15 use word 4 and pins 16 to 31 use word 3. Both words read back as written.
- R4: Trigger codes: 10 is rising edge and 11 is falling edge. An edge pin ignores the opposite edge. Its pending bit (word 7) is set at the third rising clock edge after the pad input changes.
- R5: Trigger codes: 00 is level high and 01 is level low. A level pin's pending bit is set again on every cycle the level is present, so a clear written while the level persists has no effect.
- R6: A pin's pending bit can be set only while its bit in the mask register (word 5) is one.
- R7: Writing a one to a bit of word 7 clears that pin's pending bit. Writing a zero leaves the bit unchanged.
- R8: Control word 6 holds enable at bit 0, the port pending flag at bit 1 and the sample-clock select at bit 2. Bit 1 is set by any unmasked pin event and is cleared only by writing a one to it. Bits 0 and 2 read back as written.
- R9: irq is high exactly when the enable bit is set and some pin has both its pending bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed word (combinational) |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enables |
| pad_ie | output | NPINS | Pad input enables |
| irq | output | 1 | Port interrupt |

## Verification
A wrong previous-value register or a wrong trigger decode appears at the ports as a pending bit. That bit is missing, or is set on the wrong edge, by the third clock edge after a pad change. It is visible on irq in the same cycle it is set. A pending register that fails to clear, or clears where it should be re-set, is visible on the read immediately after the write-one. A misplaced trigger field makes a pin react with another pin's type, which the edge and level tests expose within a few cycles.

// File: rtl/gip_pkg.sv
package gip_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;
    localparam int HALF_PINS = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_OE      = 3'd0,
        A_IE      = 3'd1,
        A_DATA    = 3'd2,
        A_TRIG_HI = 3'd3,
        A_TRIG_LO = 3'd4,
        A_MASK    = 3'd5,
        A_CTRL    = 3'd6,
        A_PEND    = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRG_LVL_HI = 2'b00,
        TRG_LVL_LO = 2'b01,
        TRG_RISE   = 2'b10,
        TRG_FALL   = 2'b11
    } trig_e;

    typedef struct packed {
        logic clksel;
        logic pend;
        logic en;
    } ctrl_t;

    function automatic logic trig_hit(trig_e t, logic cur, logic prev);
        case (t)
            TRG_LVL_HI: trig_hit = cur;
            TRG_LVL_LO: trig_hit = ~cur;
            TRG_RISE:   trig_hit = cur & ~prev;
            default:    trig_hit = ~cur & prev;
        endcase
    endfunction

endpackage

// File: rtl/gip_sync.sv
module gip_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gip_detect.sv
module gip_detect
    import gip_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   cur,
    input  logic [2*N-1:0] trig,
    output logic [N-1:0]   evt
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign evt[i] = trig_hit(trig_e'(trig[2*i +: 2]), cur[i], prev[i]);
    end
endmodule

// File: rtl/gip_pending.sv
module gip_pending #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    input  logic         port_clr,
    output logic [N-1:0] pend,
    output logic         port_pend
);
    logic [N-1:0] hits;

    assign hits = evt & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            port_pend <= 1'b0;
        end else begin
            pend      <= (pend & ~clr) | hits;
            port_pend <= (port_pend & ~port_clr) | (|hits);
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gip_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_ie,
    output logic              irq
);
    localparam int TW = 2 * NPINS;

    logic [NPINS-1:0]  oe_q, ie_q, dat_q, mask_q;
    logic [WORD_W-1:0] trig_hi_q, trig_lo_q;
    ctrl_t             ctrl_q;
    logic [NPINS-1:0]  pin_sync, evt, pend, pend_clr;
    logic [TW-1:0]     trig_vec;
    logic              port_pend, port_clr;
    reg_addr_e         waddr;

    assign waddr = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q      <= '0;
            ie_q      <= '0;
            dat_q     <= '0;
            mask_q    <= '0;
            trig_hi_q <= '0;
            trig_lo_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_en) begin
            case (waddr)
                A_OE:      oe_q      <= wr_data[NPINS-1:0];
                A_IE:      ie_q      <= wr_data[NPINS-1:0];
                A_DATA:    dat_q     <= wr_data[NPINS-1:0];
                A_TRIG_HI: trig_hi_q <= wr_data;
                A_TRIG_LO: trig_lo_q <= wr_data;
                A_MASK:    mask_q    <= wr_data[NPINS-1:0];
                A_CTRL: begin
                    ctrl_q.en     <= wr_data[0];
                    ctrl_q.clksel <= wr_data[2];
                end
                default: ;
            endcase
        end
    end

    assign pend_clr = (wr_en && waddr == A_PEND) ? wr_data[NPINS-1:0] : '0;
    assign port_clr = wr_en && waddr == A_CTRL && wr_data[1];

    for (genvar i = 0; i < NPINS; i++) begin : g_trig
        if (i < HALF_PINS) begin : g_lo
            assign trig_vec[2*i +: 2] = trig_lo_q[2*(i % HALF_PINS) +: 2];
        end else begin : g_hi
            assign trig_vec[2*i +: 2] = trig_hi_q[2*(i % HALF_PINS) +: 2];
        end
    end

    gip_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
    );

    gip_detect #(.N(NPINS)) u_det (
        .clk(clk), .rst(rst), .cur(pin_sync), .trig(trig_vec), .evt(evt)
    );

    gip_pending #(.N(NPINS)) u_pend (
        .clk(clk), .rst(rst), .evt(evt), .mask(mask_q), .clr(pend_clr),
        .port_clr(port_clr), .pend(pend), .port_pend(port_pend)
    );

    always_comb begin
        rd_data = '0;
        case (waddr)
            A_OE:      rd_data[NPINS-1:0] = oe_q;
            A_IE:      rd_data[NPINS-1:0] = ie_q;
            A_DATA:    rd_data[NPINS-1:0] = (oe_q & dat_q) | (~oe_q & pin_sync);
            A_TRIG_HI: rd_data = trig_hi_q;
            A_TRIG_LO: rd_data = trig_lo_q;
            A_MASK:    rd_data[NPINS-1:0] = mask_q;
            A_CTRL:    rd_data[2:0] = {ctrl_q.clksel, port_pend, ctrl_q.en};
            default:   rd_data[NPINS-1:0] = pend;
        endcase
    end

    assign pad_out = dat_q;
    assign pad_oe  = oe_q;
    assign pad_ie  = ie_q;
    assign irq     = ctrl_q.en & (|(pend & mask_q));
endmodule

// File: rtl/gip_checker.sv
module gip_checker
    import gip_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  pad_oe,
    input logic              irq
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && pad_oe == '0));

    assert_oe_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OE) |=> pad_oe == $past(wr_data[NPINS-1:0]));

    assert_pend_source_R4: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(pend) & ~$past(evt)) == '0);

    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(pend) & ~$past(mask_q)) == '0);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_PEND)
        |=> (pend & $past(wr_data[NPINS-1:0]) & ~$past(evt)) == '0);

    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && !wr_data[0]) |=> !irq);
endmodule

bind gpio_irq_port gip_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .mask_q(mask_q), .pend(pend), .evt(evt), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_ie;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    gpio_irq_port #(.NPINS(N)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_ie(pad_ie), .irq(irq)
    );

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_data;
                1: act = {31'd0, irq};
                2: act = pad_oe;
                3: act = pad_out;
                default: act = pad_ie;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_out(int kind, logic [31:0] exp, string tag);
        sb.push_back('{kind, exp, tag});
        @(negedge clk);
        #1;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        @(posedge clk);
        #1 addr = a;
        expect_out(0, exp, tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(posedge clk);
        #1 addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic pad(int p, logic v);
        @(posedge clk);
        #1 pad_in[p] = v;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        edges(3);
        #1 rst = 1'b0;
        for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset register");
        expect_out(1, 0, "R1 reset irq");
        expect_out(2, 0, "R1 reset pad_oe");

        wr(3'd0, 32'h0000_FF00);
        wr(3'd2, 32'h0000_A500);
        wr(3'd1, 32'h00FF_0000);
        expect_out(2, 32'h0000_FF00, "R2 pad_oe");
        expect_out(3, 32'h0000_A500, "R2 pad_out");
        expect_out(4, 32'h00FF_0000, "R2 pad_ie");
        @(posedge clk); #1 pad_in = 32'h8100_0000;
        edges(3);
        rd(3'd2, 32'h8100_A500, "R2 data read mix");
        @(posedge clk); #1 pad_in = '0;
        edges(3);

        wr(3'd4, 32'h0000_0080);
        wr(3'd3, 32'h0000_0300);
        rd(3'd4, 32'h0000_0080, "R3 low trigger word");
        rd(3'd3, 32'h0000_0300, "R3 high trigger word");
        wr(3'd6, 32'h1);
        wr(3'd5, 32'h0010_0008);

        pad(3, 1'b1);
        edges(2);
        expect_out(1, 0, "R4 not yet pending after two edges");
        edges(1);
        expect_out(1, 1, "R9 irq on rising edge pin");
        rd(3'd7, 32'h0000_0008, "R4 rising pending");
        rd(3'd6, 32'h3, "R8 port pending set");

        wr(3'd7, 32'h0000_0008);
        rd(3'd7, 32'h0, "R7 pending cleared");
        expect_out(1, 0, "R9 irq after clear");
        wr(3'd6, 32'h3);
        rd(3'd6, 32'h1, "R8 port pending write-one clear");

        pad(20, 1'b1);
        edges(4);
        rd(3'd7, 32'h0, "R4 falling pin ignores rise");
        pad(20, 1'b0);
        edges(3);
        rd(3'd7, 32'h0010_0000, "R3 R4 falling pending on high word pin");
        expect_out(1, 1, "R9 irq on falling");
        wr(3'd7, 32'h0010_0000);
        rd(3'd7, 32'h0, "R7 clear falling pin");

        pad(7, 1'b1);
        edges(4);
        rd(3'd7, 32'h0, "R6 unmasked pin stays clear");
        expect_out(1, 0, "R6 irq quiet");
        pad(7, 1'b0);

        wr(3'd5, 32'h0010_0028);
        pad(5, 1'b1);
        edges(3);
        rd(3'd7, 32'h0000_0020, "R5 level high pending");
        wr(3'd7, 32'h0000_0020);
        rd(3'd7, 32'h0000_0020, "R5 level re-sets after clear");
        pad(5, 1'b0);
        edges(3);
        wr(3'd7, 32'h0000_0020);
        rd(3'd7, 32'h0, "R7 clear after level gone");

        pad(5, 1'b1);
        edges(3);
        expect_out(1, 1, "R9 irq level");
        wr(3'd6, 32'h0);
        expect_out(1, 0, "R9 irq gated by enable");
        rd(3'd7, 32'h0000_0020, "R9 pending kept while disabled");
        rd(3'd6, 32'h2, "R8 control with enable off");
        wr(3'd6, 32'h5);
        rd(3'd6, 32'h7, "R8 sample select readback");
        expect_out(1, 1, "R9 irq re-enabled");
        wr(3'd5, 32'h0010_0008);
        expect_out(1, 0, "R9 irq needs mask");
        rd(3'd7, 32'h0000_0020, "R6 pending kept when masked off");

        wr(3'd4, 32'h0000_1080);
        wr(3'd5, 32'h0010_0048);
        rd(3'd7, 32'h0000_0060, "R5 level low pending");
        expect_out(1, 1, "R9 irq level low");
        pad(6, 1'b1);
        edges(3);
        wr(3'd7, 32'h0000_0060);
        rd(3'd7, 32'h0, "R7 clear both");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule